// File: doc/BRIEF.md
# Microsecond Free-Running Timer

This block keeps a 12-bit count of elapsed microseconds for a small controller running from a 12 MHz system clock. A prescaler divides the clock by twelve into a one-cycle tick enable. The counter advances on every tick and wraps around without stopping. Two periodic interrupt strobes come from fixed taps of that count. The fast strobe fires every 128 µs and the slow strobe every 1.024 ms.

Software reaches the block through a small register bus. Reading the low count byte also captures the upper count bits, so a later read of the high register returns a value that belongs with the low byte already taken, even if a carry occurs between the two reads. Any write to the restart register clears the watchdog. If software stops writing it, the watchdog expires and drives a reset request. That request is held for a fixed 2.048 ms, after which the processor restarts from address zero. The counter and the strobes keep running while the reset request is active, because other logic depends on them.

Top module: `usec_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count, the captured high bits, the watchdog and the hold state clear. After such an edge, `irq_128us`, `irq_1ms`, `wd_reset` and an idle `bus_rdata` are all 0.
- R2: The count advances by exactly one on the last cycle of every group of `CLK_PER_TICK` cycles (12 by default, which gives 1 µs at 12 MHz). It wraps from 4095 to 0.
- R3: `irq_128us` is high for exactly one cycle. That cycle is the first one in which the low 7 count bits have returned to zero.
- R4: `irq_1ms` is high for exactly one cycle. That cycle is the first one in which the low 10 count bits have returned to zero. The fast strobe is always high in the same cycle.
- R5: A read is `bus_sel`=1 with `bus_wr`=0. A read at address 0 returns count bits 7:0 and captures bits 11:8. A read at address 1 returns the captured bits in bits 3:0, with zeros above them. Any other address, and any cycle that is not a read, returns 0.
- R6: A write is `bus_sel`=1 with `bus_wr`=1 at address 2, and it restarts the watchdog. If `WD_LIMIT` ticks (8192 by default) pass without a restart, `wd_reset` rises on the tick that completes the interval.
- R7: Once raised, `wd_reset` stays high for exactly `RST_HOLD` ticks (2048 by default, 2.048 ms). It then falls, and the watchdog starts counting again from zero.
- R8: Restart writes made while `wd_reset` is high have no effect, and the release time does not change.
- R9: The count and both strobes keep running while `wd_reset` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominally 12 MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 count low, 1 captured high, 2 watchdog restart |
| bus_rdata | output | 8 | Combinational read data |
| irq_128us | output | 1 | One-cycle strobe every 128 ticks |
| irq_1ms | output | 1 | One-cycle strobe every 1024 ticks |
| wd_reset | output | 1 | Stretched reset request after watchdog expiry |

## Verification
The bench keeps the 12-bit count and both tap positions. It shrinks the prescaler to 2, the watchdog interval to 300 ticks and the hold to 20 ticks. With these values, a full count wrap, many slow strobes, several expiries and their releases, and restart writes made during a hold all occur within about twenty thousand cycles. Reads of the low and high registers are placed around carries out of bit 7, to show that the high value stays coherent with the low byte read before it.

// File: rtl/usec_timer_pkg.sv
// Shared register decode for the microsecond timer.
// Assumes a 2-bit register address space.
package usec_timer_pkg;
    typedef enum logic [1:0] {
        ADDR_CNT_LO  = 2'd0,
        ADDR_CNT_HI  = 2'd1,
        ADDR_WD_KICK = 2'd2,
        ADDR_UNUSED  = 2'd3
    } timer_addr_e;
endpackage

// File: rtl/usec_prescaler.sv
// Divides the system clock into a one-cycle tick enable.
// Assumes DIV >= 2. The tick is high during the last cycle of each group of DIV cycles.
module usec_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [PW-1:0] phase;

    assign tick = (phase == PW'(DIV - 1));

    // Step the phase and return to zero after the tick cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= '0;
        else if (tick) phase <= '0;
        else           phase <= phase + 1'b1;
    end
endmodule

// File: rtl/usec_counter.sv
// Free-running tick counter with periodic strobes taken from its low bits.
// Assumes TAP_FAST < TAP_SLOW <= CNT_W. Each strobe is registered, so it appears
// in the same cycle as the count value whose low bits have wrapped.
module usec_counter #(
    parameter int CNT_W    = 12,
    parameter int TAP_FAST = 7,
    parameter int TAP_SLOW = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic [1:0]       strobe
);
    // Advance the count by one on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= count + 1'b1;
    end

    for (genvar g = 0; g < 2; g++) begin : g_tap
        localparam int TAP = (g == 0) ? TAP_FAST : TAP_SLOW;
        logic low_full;
        assign low_full = (count[TAP-1:0] == {TAP{1'b1}});

        // Flag the tick that carries out of the tapped low bits.
        always_ff @(posedge clk) begin
            if (!rst_n) strobe[g] <= 1'b0;
            else        strobe[g] <= tick && low_full;
        end
    end
endmodule

// File: rtl/usec_watchdog.sv
// Watchdog that counts ticks since the last restart. When it expires, it raises
// a reset request and holds it for HOLD ticks. Restarts are ignored during the hold.
// Assumes LIMIT >= 2 and HOLD >= 2.
module usec_watchdog #(
    parameter int LIMIT = 8192,
    parameter int HOLD  = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic kick,
    output logic wd_reset
);
    localparam int WW = $clog2(LIMIT);
    localparam int HW = $clog2(HOLD);

    logic [WW-1:0] idle_ticks;
    logic [HW-1:0] hold_ticks;

    // Count idle ticks, enter the hold on expiry, and leave it after HOLD ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_ticks <= '0;
            hold_ticks <= '0;
            wd_reset   <= 1'b0;
        end else if (wd_reset) begin
            if (tick) begin
                if (hold_ticks == HW'(HOLD - 1)) begin
                    wd_reset   <= 1'b0;
                    hold_ticks <= '0;
                end else begin
                    hold_ticks <= hold_ticks + 1'b1;
                end
            end
        end else if (kick) begin
            idle_ticks <= '0;
        end else if (tick) begin
            if (idle_ticks == WW'(LIMIT - 1)) begin
                wd_reset   <= 1'b1;
                idle_ticks <= '0;
            end else begin
                idle_ticks <= idle_ticks + 1'b1;
            end
        end
    end
endmodule

// File: rtl/usec_timer.sv
// Top level: prescaler, microsecond counter, watchdog and a register port.
// Assumes 8 < CNT_W <= 16. A read of the low byte captures the upper bits, and
// address 1 returns the captured bits.
module usec_timer #(
    parameter int CLK_PER_TICK = 12,
    parameter int CNT_W        = 12,
    parameter int TAP_FAST     = 7,
    parameter int TAP_SLOW     = 10,
    parameter int WD_LIMIT     = 8192,
    parameter int RST_HOLD     = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    output logic [7:0] bus_rdata,
    output logic       irq_128us,
    output logic       irq_1ms,
    output logic       wd_reset
);
    import usec_timer_pkg::*;

    localparam int HI_W = CNT_W - 8;

    logic             tick;
    logic [CNT_W-1:0] count;
    logic [1:0]       strobe;
    logic [HI_W-1:0]  hi_capture;
    logic             rd_lo;
    logic             rd_hi;
    logic             kick;

    assign rd_lo = bus_sel && !bus_wr && (bus_addr == ADDR_CNT_LO);
    assign rd_hi = bus_sel && !bus_wr && (bus_addr == ADDR_CNT_HI);
    assign kick  = bus_sel &&  bus_wr && (bus_addr == ADDR_WD_KICK);

    usec_prescaler #(.DIV(CLK_PER_TICK)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    usec_counter #(.CNT_W(CNT_W), .TAP_FAST(TAP_FAST), .TAP_SLOW(TAP_SLOW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .count (count),
        .strobe(strobe)
    );

    usec_watchdog #(.LIMIT(WD_LIMIT), .HOLD(RST_HOLD)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .kick    (kick),
        .wd_reset(wd_reset)
    );

    assign irq_128us = strobe[0];
    assign irq_1ms   = strobe[1];

    // Capture the upper count bits whenever the low byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_capture <= '0;
        else if (rd_lo) hi_capture <= count[CNT_W-1:8];
    end

    // Select the read data; the output is zero unless a register is being read.
    always_comb begin
        if (rd_lo)      bus_rdata = count[7:0];
        else if (rd_hi) bus_rdata = 8'(hi_capture);
        else            bus_rdata = 8'h00;
    end
endmodule

// File: rtl/usec_timer_chk.sv
// Temporal checks on the timer, attached to every instance by bind.
module usec_timer_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [7:0]       bus_rdata,
    input logic             irq_128us,
    input logic             irq_1ms,
    input logic             wd_reset
);
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> count == $past(count) + 1'b1);
    // R3
    fast_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_128us |=> !irq_128us);
    // R4
    slow_in_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_1ms |-> irq_128us);
    // R7
    wd_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(wd_reset));
    // R5
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |-> bus_rdata == 8'h00);
endmodule

bind usec_timer usec_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .count    (count),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_rdata(bus_rdata),
    .irq_128us(irq_128us),
    .irq_1ms  (irq_1ms),
    .wd_reset (wd_reset)
);

// File: tb/usec_timer_test.sv
module usec_timer_test;
    localparam int P = 2;
    localparam int L = 300;
    localparam int H = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd3;
    logic [7:0] bus_rdata;
    logic       irq_128us, irq_1ms, wd_reset;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit comparing = 0;

    // behavioural reference state
    int m_pre, m_cnt, m_wd, m_hold, m_hc, m_shadow, m_fast, m_slow;
    int run_len = 0;
    int rises = 0;

    usec_timer #(.CLK_PER_TICK(P), .CNT_W(12), .WD_LIMIT(L), .RST_HOLD(H)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_rdata(bus_rdata),
        .irq_128us(irq_128us), .irq_1ms(irq_1ms), .wd_reset(wd_reset)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model: advances on every edge using inputs held stable around it.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_wd = 0; m_hold = 0; m_hc = 0;
            m_shadow = 0; m_fast = 0; m_slow = 0;
        end else begin
            bit tk;
            bit kick;
            tk = (m_pre == P - 1);
            kick = bus_sel && bus_wr && bus_addr == 2'd2;
            if (bus_sel && !bus_wr && bus_addr == 2'd0) m_shadow = m_cnt / 256;
            m_fast = tk && ((m_cnt + 1) % 128 == 0);
            m_slow = tk && ((m_cnt + 1) % 1024 == 0);
            if (m_hold != 0) begin
                if (tk) begin
                    if (m_hc == H - 1) begin m_hold = 0; m_hc = 0; end
                    else m_hc++;
                end
            end else if (kick) m_wd = 0;
            else if (tk) begin
                if (m_wd == L - 1) begin m_hold = 1; m_wd = 0; end
                else m_wd++;
            end
            if (tk) m_cnt = (m_cnt + 1) % 4096;
            m_pre = tk ? 0 : m_pre + 1;
        end
    end

    // Compare every output with the model, away from the active edge.
    always @(negedge clk) begin
        if (comparing) begin
            int exp_rd;
            exp_rd = 0;
            if (bus_sel && !bus_wr && bus_addr == 2'd0) exp_rd = m_cnt % 256;
            if (bus_sel && !bus_wr && bus_addr == 2'd1) exp_rd = m_shadow;
            check("R3 irq_128us", int'(irq_128us), m_fast);
            check("R4 irq_1ms", int'(irq_1ms), m_slow);
            check("R6/R8 wd_reset", int'(wd_reset), m_hold);
            check("R2/R5 bus_rdata", int'(bus_rdata), exp_rd);
            if (wd_reset) run_len++;
            else if (run_len != 0) begin
                check("R7 hold length in cycles", run_len, H * P);
                run_len = 0;
            end
            if (wd_reset && run_len == 1) rises++;
        end
    end

    // Run-time limit: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL timeout: actual %0d cycles expected below %0d", cycles, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic access(input bit wr, input logic [1:0] a);
        @(posedge clk); #2;
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a;
        @(posedge clk); #2;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd3;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        idle(4);
        @(negedge clk);
        // R1: outputs during and right after reset
        check("R1 irq_128us", int'(irq_128us), 0);
        check("R1 irq_1ms", int'(irq_1ms), 0);
        check("R1 wd_reset", int'(wd_reset), 0);
        check("R1 bus_rdata", int'(bus_rdata), 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        comparing = 1;
        // R1/R2: first low read sees a count that started from zero
        access(1'b0, 2'd0);
        // R6: regular restarts prevent expiry
        for (int i = 0; i < 30; i++) begin
            idle(150);
            access(1'b1, 2'd2);
            access(1'b0, 2'd0);
            idle(3 + i % 5);
            access(1'b0, 2'd1);
        end
        check("R6 no expiry while restarted", rises, 0);
        // R6/R7/R8: let it expire, restart during the hold
        idle(L * P + 4);
        check("R6 expiry seen", rises, 1);
        access(1'b1, 2'd2);
        idle(5);
        access(1'b1, 2'd2);
        idle(H * P + 10);
        // R5: reads around carries out of bit 7, with other addresses in between
        for (int i = 0; i < 40; i++) begin
            access(1'b0, 2'd0);
            idle(i * 7 % 13);
            access(1'b0, 2'd3);
            access(1'b0, 2'd1);
            access(1'b1, 2'd0);
            idle(40 + i);
        end
        // R2/R4/R9: run past a full count wrap with expiries and holds occurring
        idle(9000);
        check("R9 several expiries", int'(rises > 3), 1);
        comparing = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule